// File: doc/BRIEF.md
# Word-Line-Major March C- Self-Test Controller

This controller runs a March C- memory test on a synchronous single-port SRAM. The SRAM's logical address is split into a row (word line) index and a column-group index. Every element of the test visits all column groups of one row before it opens the next row. Ascending and descending elements both keep this order. The result is long unbroken runs of accesses to the same word line. Each of those accesses puts read-equivalent stress on the unselected cells of that row, which helps expose weak cells that slowly lose their data under that stress.

The controller drives one memory operation per clock cycle: a row index, a column-group index, a write enable with write data, or a read enable. Read data comes back one cycle after the read and is compared on every bit against the expected background. The first failure is recorded: its row, its column group and the element in which it happened. The fail flag is sticky.

An optional noise mode adds switching activity without changing what the test expects to find. Before every read, the controller writes an all-ones or all-zeros word to the neighbouring column group of the same row. That write stores exactly the value the neighbour is supposed to hold at that point in the test.

Top module: `march_wl_bist`

## Requirements
- R1: While reset is held, and afterwards until a start is accepted, `busy`, `done` and `fail` are low and neither `mem_we` nor `mem_re` is asserted.
- R2: A `start` pulse is accepted only while `busy` is low. When accepted, it clears `done` and `fail`, latches `noise_en`, and makes `busy` high from the next cycle. A `start` seen while `busy` is high has no effect on the operation stream or on the run length.
- R3: The elements run in this order, and each element performs these operations at every address:
  - element 0: write 0
  - element 1: read 0, then write 1
  - element 2: read 1, then write 0
  - element 3: read 0, then write 1
  - element 4: read 1, then write 0
  - element 5: read 0
  A written 0 or 1 is that bit replicated across the whole word. Operations issue back to back, one per cycle, with no idle cycles between addresses or between elements.
- R4: Word-line-major order. The column group changes fastest. Elements 0, 1, 2 and 5 run rows upward from 0 and, within each row, column groups upward from 0. Elements 3 and 4 run rows downward from the top row and, within each row, column groups downward from the top column group.
- R5: Read data is sampled in the cycle after `mem_re`. Every bit is compared against the element's expected bit (0 for elements 1, 3 and 5; 1 for elements 2 and 4).
- R6: On the first mismatch, `fail` goes high and stays high until the next accepted start. `fail_row`, `fail_col` and `fail_elem` hold the row, column group and element index (0 to 5) of that first failing read. They do not change for later mismatches.
- R7: `done` rises together with the final verdict of the last read, one cycle after the last operation. With W words, that is W*10+1 clock edges after the edge that accepts `start` without noise, and W*15+1 with noise. At the same edge `busy` falls. `done` then stays high until the next accepted start.
- R8: With noise latched, every read in elements 1 to 5 is preceded by a write to column group (col XOR 1) of the same row. The noise write puts a replicated value into that neighbour group:
  - the element's write bit, if the current element has already passed that neighbour;
  - otherwise, the element's read bit.
- R9: At most one of `mem_we` and `mem_re` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, accepted while idle |
| noise_en | input | 1 | Selects noise mode for the next run |
| mem_row | output | ROW_W | Row (word line) index |
| mem_col | output | COL_W | Column-group index |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe, data expected next cycle |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, one cycle after mem_re |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished, verdict valid |
| fail | output | 1 | Sticky mismatch flag |
| fail_row | output | ROW_W | Row of first failing read |
| fail_col | output | COL_W | Column group of first failing read |
| fail_elem | output | 3 | Element index of first failing read |

## Verification
A wrong step or element counter shows at the ports in the very next cycle. The operation stream then departs from the bench's model: a missing read, a doubled write, or a wrong background. A bad address counter shows the first time a row changes before its last column group, or when a descending element starts at the wrong end. The bench compares every memory operation of every run against an independently built expected stream, so either error appears within one cycle of going wrong. A fault in the comparator or in the capture logic shows as a wrong verdict or wrong failure coordinates at `done`. To catch that, stuck-at cells are injected at random places with random polarity.

// File: rtl/march_pkg.sv
package march_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_NOISE = 2'd1,
    OP_READ  = 2'd2,
    OP_WRITE = 2'd3
  } op_e;

  localparam logic [2:0] LAST_ELEM = 3'd5;

  // Elements 3 and 4 run downward; all others run upward.
  function automatic logic elem_up(input logic [2:0] e);
    return !(e == 3'd3 || e == 3'd4);
  endfunction

  // Expected read background of an element.
  function automatic logic elem_rd_bit(input logic [2:0] e);
    return (e == 3'd2 || e == 3'd4);
  endfunction

  // Value written by an element.
  function automatic logic elem_wr_bit(input logic [2:0] e);
    return (e == 3'd1 || e == 3'd3);
  endfunction

  // Operation at a given step of one address.
  function automatic op_e op_at(input logic [2:0] e, input logic nz,
                                input logic [1:0] s);
    logic [1:0] k;
    k = s;
    if (e != 3'd0 && nz) begin
      if (k == 2'd0) return OP_NOISE;
      k = k - 2'd1;
    end
    if (e != 3'd0) begin
      if (k == 2'd0) return OP_READ;
      k = k - 2'd1;
    end
    if (e != LAST_ELEM && k == 2'd0) return OP_WRITE;
    return OP_NONE;
  endfunction

endpackage

// File: rtl/march_addr_gen.sv
module march_addr_gen #(
  parameter int ROW_W = 9,
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_up,
  input  logic             adv,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic             up,
  output logic             at_last
);
  localparam logic [ROW_W-1:0] ROW_TOP = '1;
  localparam logic [COL_W-1:0] COL_TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row <= '0;
      col <= '0;
      up  <= 1'b1;
    end else if (load) begin
      up  <= load_up;
      row <= load_up ? '0 : ROW_TOP;
      col <= load_up ? '0 : COL_TOP;
    end else if (adv) begin
      if (up) begin
        if (col == COL_TOP) begin
          col <= '0;
          row <= row + 1'b1;
        end else begin
          col <= col + 1'b1;
        end
      end else begin
        if (col == '0) begin
          col <= COL_TOP;
          row <= row - 1'b1;
        end else begin
          col <= col - 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (up) at_last = (row == ROW_TOP) && (col == COL_TOP);
    else    at_last = (row == '0) && (col == '0);
  end
endmodule

// File: rtl/march_seq.sv
module march_seq
  import march_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       noise_en,
  input  logic       at_last,
  output op_e        op,
  output logic [2:0] elem,
  output logic       busy,
  output logic       done,
  output logic       in_run,
  output logic       start_ok,
  output logic       ag_load,
  output logic       ag_load_up,
  output logic       ag_adv
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} state_e;

  state_e     state;
  logic [1:0] step;
  logic       noise_q;
  logic       last_step;
  logic       elem_end;

  assign busy      = (state != S_IDLE);
  assign in_run    = (state == S_RUN);
  assign start_ok  = start && !busy;
  assign op        = in_run ? op_at(elem, noise_q, step) : OP_NONE;
  assign last_step = (op_at(elem, noise_q, step + 2'd1) == OP_NONE);
  assign elem_end  = in_run && last_step && at_last;

  assign ag_load    = start_ok || (elem_end && elem != LAST_ELEM);
  assign ag_load_up = start_ok ? 1'b1 : elem_up(elem + 3'd1);
  assign ag_adv     = in_run && last_step && !at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      step    <= '0;
      elem    <= '0;
      noise_q <= 1'b0;
      done    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start_ok) begin
          state   <= S_RUN;
          step    <= '0;
          elem    <= '0;
          noise_q <= noise_en;
          done    <= 1'b0;
        end
        S_RUN: begin
          if (!last_step) begin
            step <= step + 2'd1;
          end else begin
            step <= '0;
            if (at_last) begin
              if (elem == LAST_ELEM) state <= S_DRAIN;
              else                   elem  <= elem + 3'd1;
            end
          end
        end
        S_DRAIN: begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/march_resp_chk.sv
module march_resp_chk #(
  parameter int ROW_W  = 9,
  parameter int COL_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rd_issue,
  input  logic              exp_bit,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic [2:0]        elem,
  input  logic [DATA_W-1:0] rdata,
  output logic              fail,
  output logic [ROW_W-1:0]  fail_row,
  output logic [COL_W-1:0]  fail_col,
  output logic [2:0]        fail_elem
);
  logic              pend_v;
  logic              pend_exp;
  logic [ROW_W-1:0]  pend_row;
  logic [COL_W-1:0]  pend_col;
  logic [2:0]        pend_elem;
  logic [DATA_W-1:0] lane_bad;
  logic              any_bad;

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign lane_bad[i] = (rdata[i] != pend_exp);
  end
  assign any_bad = pend_v && (|lane_bad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_exp  <= 1'b0;
      pend_row  <= '0;
      pend_col  <= '0;
      pend_elem <= '0;
    end else begin
      pend_v <= rd_issue;
      if (rd_issue) begin
        pend_exp  <= exp_bit;
        pend_row  <= row;
        pend_col  <= col;
        pend_elem <= elem;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail      <= 1'b0;
      fail_row  <= '0;
      fail_col  <= '0;
      fail_elem <= '0;
    end else if (clear) begin
      fail      <= 1'b0;
      fail_row  <= '0;
      fail_col  <= '0;
      fail_elem <= '0;
    end else if (any_bad && !fail) begin
      fail      <= 1'b1;
      fail_row  <= pend_row;
      fail_col  <= pend_col;
      fail_elem <= pend_elem;
    end
  end
endmodule

// File: rtl/march_wl_bist.sv
module march_wl_bist
  import march_pkg::*;
#(
  parameter int ROW_W  = 9,
  parameter int COL_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              noise_en,
  output logic [ROW_W-1:0]  mem_row,
  output logic [COL_W-1:0]  mem_col,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ROW_W-1:0]  fail_row,
  output logic [COL_W-1:0]  fail_col,
  output logic [2:0]        fail_elem
);
  localparam logic [COL_W-1:0] NBR_FLIP = COL_W'(1);

  op_e              op;
  logic [2:0]       elem;
  logic             in_run;
  logic             start_ok;
  logic             ag_load;
  logic             ag_load_up;
  logic             ag_adv;
  logic [ROW_W-1:0] cur_row;
  logic [COL_W-1:0] cur_col;
  logic             cur_up;
  logic             at_last;
  logic             nbr_passed;
  logic             wbit;

  march_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .noise_en   (noise_en),
    .at_last    (at_last),
    .op         (op),
    .elem       (elem),
    .busy       (busy),
    .done       (done),
    .in_run     (in_run),
    .start_ok   (start_ok),
    .ag_load    (ag_load),
    .ag_load_up (ag_load_up),
    .ag_adv     (ag_adv)
  );

  march_addr_gen #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ag_load),
    .load_up (ag_load_up),
    .adv     (ag_adv),
    .row     (cur_row),
    .col     (cur_col),
    .up      (cur_up),
    .at_last (at_last)
  );

  // Neighbour col^1 already visited: below us going up, above us going down.
  assign nbr_passed = cur_up ? cur_col[0] : !cur_col[0];

  always_comb begin
    if (op == OP_NOISE)
      wbit = nbr_passed ? elem_wr_bit(elem) : elem_rd_bit(elem);
    else
      wbit = elem_wr_bit(elem);
  end

  assign mem_row   = cur_row;
  assign mem_col   = (op == OP_NOISE) ? (cur_col ^ NBR_FLIP) : cur_col;
  assign mem_we    = (op == OP_WRITE) || (op == OP_NOISE);
  assign mem_re    = (op == OP_READ);
  assign mem_wdata = {DATA_W{wbit}};

  march_resp_chk #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_ok),
    .rd_issue  (mem_re),
    .exp_bit   (elem_rd_bit(elem)),
    .row       (cur_row),
    .col       (cur_col),
    .elem      (elem),
    .rdata     (mem_rdata),
    .fail      (fail),
    .fail_row  (fail_row),
    .fail_col  (fail_col),
    .fail_elem (fail_elem)
  );
endmodule

// File: rtl/march_wl_bist_chk.sv
module march_wl_bist_chk #(
  parameter int ROW_W = 9,
  parameter int COL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             fail,
  input logic             mem_we,
  input logic             mem_re,
  input logic [ROW_W-1:0] fail_row,
  input logic [COL_W-1:0] fail_col,
  input logic [2:0]       fail_elem,
  input logic             in_run,
  input logic [ROW_W-1:0] cur_row,
  input logic [COL_W-1:0] cur_col
);
  localparam logic [COL_W-1:0] COL_TOP = '1;

  p_one_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re));

  p_fail_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !(start && !busy)) |=> fail);

  p_fail_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && $past(fail)) |-> ($stable(fail_row) && $stable(fail_col) && $stable(fail_elem)));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_row_after_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && $past(in_run) && cur_row != $past(cur_row))
      |-> ($past(cur_col) == '0 || $past(cur_col) == COL_TOP));
endmodule

bind march_wl_bist march_wl_bist_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_bind_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .fail      (fail),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .fail_row  (fail_row),
  .fail_col  (fail_col),
  .fail_elem (fail_elem),
  .in_run    (in_run),
  .cur_row   (cur_row),
  .cur_col   (cur_col)
);

// File: tb/test_march_wl_bist.sv
`timescale 1ns/1ps
module test_march_wl_bist;
  localparam int RW = 3;
  localparam int CW = 2;
  localparam int DW = 8;
  localparam int NR = 1 << RW;
  localparam int NC = 1 << CW;
  localparam int WORDS = NR * NC;
  localparam int MAXOPS = 15 * WORDS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          noise_en = 1'b0;
  logic [RW-1:0] mem_row;
  logic [CW-1:0] mem_col;
  logic          mem_we, mem_re;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          busy, done, fail;
  logic [RW-1:0] fail_row;
  logic [CW-1:0] fail_col;
  logic [2:0]    fail_elem;

  always #4 clk = ~clk;

  march_wl_bist #(.ROW_W(RW), .COL_W(CW), .DATA_W(DW)) i_march_wl_bist (
    .clk(clk), .rst_n(rst_n), .start(start), .noise_en(noise_en),
    .mem_row(mem_row), .mem_col(mem_col), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .fail(fail), .fail_row(fail_row), .fail_col(fail_col), .fail_elem(fail_elem)
  );

  // Memory model with one optional stuck-at bit.
  logic [DW-1:0] mem [WORDS];
  logic          f_on = 1'b0;
  int            f_addr = 0;
  int            f_bit = 0;
  logic          f_val = 1'b0;

  always @(posedge clk) begin
    if (mem_we) mem[{mem_row, mem_col}] <= mem_wdata;
    if (mem_re) begin
      logic [DW-1:0] v;
      v = mem[{mem_row, mem_col}];
      if (f_on && int'({mem_row, mem_col}) == f_addr) v[f_bit] = f_val;
      mem_rdata <= v;
    end
  end

  int n_total = 0;
  int n_fail = 0;
  longint cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 190000", cyc);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected operation stream, built from the requirement text.
  bit          t_we  [MAXOPS];
  bit          t_re  [MAXOPS];
  int          t_row [MAXOPS];
  int          t_col [MAXOPS];
  bit          t_bit [MAXOPS];
  int          n_ops;
  bit          x_fail;
  int          x_row, x_col, x_elem;

  function automatic bit rd_of(int e); return (e == 2 || e == 4); endfunction
  function automatic bit wr_of(int e); return (e == 1 || e == 3); endfunction

  task automatic push(bit we, bit re, int r, int c, bit b, int e);
    t_we[n_ops] = we; t_re[n_ops] = re; t_row[n_ops] = r;
    t_col[n_ops] = c; t_bit[n_ops] = b;
    n_ops++;
    if (re && f_on && !x_fail && (r * NC + c) == f_addr && f_val != b) begin
      x_fail = 1; x_row = r; x_col = c; x_elem = e;
    end
  endtask

  task automatic build(bit nz);
    n_ops = 0; x_fail = 0; x_row = 0; x_col = 0; x_elem = 0;
    for (int e = 0; e < 6; e++) begin
      bit dn;
      dn = (e == 3 || e == 4);
      for (int ri = 0; ri < NR; ri++) begin
        for (int ci = 0; ci < NC; ci++) begin
          int r, c, nb;
          r = dn ? NR - 1 - ri : ri;
          c = dn ? NC - 1 - ci : ci;
          nb = c ^ 1;
          if (e > 0 && nz)
            push(1, 0, r, nb, (dn ? nb > c : nb < c) ? wr_of(e) : rd_of(e), e);
          if (e > 0) push(0, 1, r, c, rd_of(e), e);
          if (e < 5) push(1, 0, r, c, wr_of(e), e);
        end
      end
    end
  endtask

  task automatic run(bit nz, bit mid_start, string tag);
    int idx, bad, cnt, first_bad;
    build(nz);
    for (int i = 0; i < WORDS; i++) mem[i] = DW'($urandom);
    idx = 0; bad = 0; cnt = 0; first_bad = -1;
    @(negedge clk);
    start = 1; noise_en = nz;
    @(negedge clk);
    start = 0; noise_en = !nz;
    check(busy === 1'b1 && done === 1'b0, "R2", {tag, " busy after start"}, busy, 1);
    forever begin
      if (mem_we || mem_re) begin
        if (idx >= n_ops || mem_we !== t_we[idx] || mem_re !== t_re[idx] ||
            int'(mem_row) != t_row[idx] || int'(mem_col) != t_col[idx] ||
            (mem_we && mem_wdata !== {DW{t_bit[idx]}})) begin
          bad++;
          if (first_bad < 0) first_bad = idx;
        end
        idx++;
      end
      if (done || cnt > MAXOPS + 10) break;
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (mid_start) start = (cnt == 4);
    end
    start = 0;
    check(bad == 0 && idx == n_ops, nz ? "R8" : "R3",
          {tag, " op stream (R4 order)"}, first_bad, -1);
    check(cnt == n_ops + 1, mid_start ? "R2" : "R7", {tag, " cycles to done"},
          cnt, n_ops + 1);
    check(busy === 1'b0, "R7", {tag, " busy low at done"}, busy, 0);
    check(fail === x_fail, "R5", {tag, " verdict"}, fail, x_fail);
    if (x_fail) begin
      check(int'(fail_row) == x_row, "R6", {tag, " fail row"}, fail_row, x_row);
      check(int'(fail_col) == x_col, "R6", {tag, " fail col"}, fail_col, x_col);
      check(int'(fail_elem) == x_elem, "R6", {tag, " fail elem"}, fail_elem, x_elem);
    end
    repeat (3) @(negedge clk);
    check(done === 1'b1 && fail === x_fail, "R7", {tag, " done/fail held"}, done, 1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    check(busy === 0 && done === 0 && fail === 0 && mem_we === 0 && mem_re === 0,
          "R1", "outputs in reset", {busy, done, fail, mem_we, mem_re}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(busy === 0 && mem_we === 0 && mem_re === 0, "R1", "idle after reset", busy, 0);
    check(mem_we !== 1'b1 || mem_re !== 1'b1, "R9", "single op", 0, 0);

    f_on = 0; run(0, 0, "clean plain");
    f_on = 0; run(1, 0, "clean noise");
    f_on = 0; run(0, 1, "start while busy");
    // Directed corners: stuck-at-1 in first cell (caught in M1),
    // stuck-at-0 in last cell (caught in M2, R4 order).
    f_on = 1; f_addr = 0; f_bit = 0; f_val = 1; run(0, 0, "sa1 first cell");
    f_on = 1; f_addr = WORDS - 1; f_bit = DW - 1; f_val = 0; run(1, 0, "sa0 last cell");
    for (int k = 0; k < 10; k++) begin
      f_on = 1;
      f_addr = $urandom_range(WORDS - 1, 0);
      f_bit = $urandom_range(DW - 1, 0);
      f_val = $urandom_range(1, 0);
      run($urandom_range(1, 0), 0, "random fault");
    end
    f_on = 0; run(0, 0, "clean after faults");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule